// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two complete direction predictors run side by side on every fetch address. The local side keeps a short outcome history for each branch slot, selected by low address bits. That history picks a counter in one pattern table shared by all branches. The global side keeps one history of the most recent outcomes across all branches. That history picks a counter in a second table and uses no address bits. A chooser table, also indexed by the global history, decides which of the two answers reaches the output.

The prediction port is purely combinational. A fetch address goes in, and the taken bit, the chooser's selection and a snapshot word come out. The pipeline carries the snapshot alongside the branch. When the branch resolves, the update port receives the branch address, the real outcome and that snapshot. All counter training then uses the indices stored in the snapshot, not whatever the histories hold by then. Each chooser entry is a four-state machine: `CH_STRONG_LOCAL`, `CH_WEAK_LOCAL`, `CH_WEAK_GLOBAL` and `CH_STRONG_GLOBAL`. It has two transitions. `GLOBAL_WIN` (only the global guess was right) steps one state toward `CH_STRONG_GLOBAL`. `LOCAL_WIN` (only the local guess was right) steps one state toward `CH_STRONG_LOCAL`. Every other case holds the state. Both end states saturate.

Top module: `tourn_pred`

## Requirements
- R1: After reset, every local pattern counter holds 3, every global counter holds 1, every chooser entry is `CH_WEAK_LOCAL`, and all histories are zero. Any address therefore predicts not-taken with `pred_use_global` = 0 and `pred_snap` = 0.
- R2: The local guess reads the history row selected by `pred_pc[PC_LSB+LROW_W-1:PC_LSB]`. That history value indexes the local pattern table, and counter values 4–7 mean taken. The guess is reported in `pred_snap[1]`, and the history value in `pred_snap[LH_W+1:2]`.
- R3: The global guess reads the global pattern table at the current global history. Counter values 2–3 mean taken. The guess is reported in `pred_snap[0]`, and the history in the top `GH_W` bits of `pred_snap`.
- R4: The chooser entry at the current global history selects the output. Encodings are 0 = `CH_STRONG_LOCAL`, 1 = `CH_WEAK_LOCAL`, 2 = `CH_WEAK_GLOBAL` and 3 = `CH_STRONG_GLOBAL`. Values 2–3 drive `pred_taken` from the global guess and set `pred_use_global`. Values 0–1 drive `pred_taken` from the local guess.
- R5: On a clock edge with `upd_valid` high, two histories shift left by one with `upd_taken` (1 = taken) entering bit 0. These are the history row selected by `upd_pc` and the global history. A prediction in that same cycle still reads the old state.
- R6: On an update, the local counter at the snapshot's local history and the global counter at the snapshot's global history each train. They step up on taken and down on not-taken, saturating at 0 and 7 (local) or 0 and 3 (global).
- R7: On an update, the chooser entry at the snapshot's global history takes `GLOBAL_WIN` or `LOCAL_WIN` when exactly one guess in the snapshot matched `upd_taken`. Otherwise it is unchanged.
- R8: Updates use the indices stored in the snapshot, so predictions made between a branch's prediction and its update do not change which entries that update trains.
- R9: With `upd_valid` low, no history or table changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_use_global | output | 1 | 1 when the global guess was selected |
| pred_snap | output | GH_W+LH_W+2 | {global history, local history, local guess, global guess} |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_snap | input | GH_W+LH_W+2 | Snapshot returned from prediction time |

## Verification
The bench builds the block with 8 local history rows, 4-bit local histories (a 16-entry shared pattern table) and a 5-bit global history (32 global counters and 32 chooser entries). Twelve branch addresses then alias onto the 8 rows. Histories wrap through all their values within a few dozen branches, and every counter reaches both saturation ends. Updates trail their predictions by two cycles, so the stored-index rule and the same-cycle read of old state are exercised on almost every step.

// File: rtl/tpred_pkg.sv
package tpred_pkg;

    typedef enum logic [1:0] {
        CH_STRONG_LOCAL  = 2'd0,
        CH_WEAK_LOCAL    = 2'd1,
        CH_WEAK_GLOBAL   = 2'd2,
        CH_STRONG_GLOBAL = 2'd3
    } chooser_e;

    // One chooser step: GLOBAL_WIN moves toward strong-global,
    // LOCAL_WIN toward strong-local, anything else holds.
    function automatic chooser_e chooser_next(chooser_e cur, logic local_ok, logic global_ok);
        chooser_e nxt;
        nxt = cur;
        if (global_ok && !local_ok) begin
            unique case (cur)
                CH_STRONG_LOCAL:  nxt = CH_WEAK_LOCAL;
                CH_WEAK_LOCAL:    nxt = CH_WEAK_GLOBAL;
                CH_WEAK_GLOBAL:   nxt = CH_STRONG_GLOBAL;
                CH_STRONG_GLOBAL: nxt = CH_STRONG_GLOBAL;
            endcase
        end else if (local_ok && !global_ok) begin
            unique case (cur)
                CH_STRONG_LOCAL:  nxt = CH_STRONG_LOCAL;
                CH_WEAK_LOCAL:    nxt = CH_STRONG_LOCAL;
                CH_WEAK_GLOBAL:   nxt = CH_WEAK_LOCAL;
                CH_STRONG_GLOBAL: nxt = CH_WEAK_GLOBAL;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tp_local.sv
module tp_local #(
    parameter int ROW_W = 10,
    parameter int LH_W  = 10,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] rd_row,
    output logic [LH_W-1:0]  rd_hist,
    output logic             rd_taken,
    input  logic             upd_valid,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             upd_taken,
    input  logic [LH_W-1:0]  upd_hist
);
    localparam int ROWS = 1 << ROW_W;
    localparam int PHT_N = 1 << LH_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_WEAK_NT = CNT_MAX >> 1;

    logic [LH_W-1:0]  hist_q [ROWS];
    logic [CNT_W-1:0] pht_q  [PHT_N];
    logic [CNT_W-1:0] cnt_cur, cnt_nxt;

    assign rd_hist  = hist_q[rd_row];
    assign rd_taken = pht_q[rd_hist][CNT_W-1];

    always_comb begin
        cnt_cur = pht_q[upd_hist];
        cnt_nxt = cnt_cur;
        if (upd_taken && cnt_cur != CNT_MAX)
            cnt_nxt = cnt_cur + 1'b1;
        else if (!upd_taken && cnt_cur != '0)
            cnt_nxt = cnt_cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) hist_q[i] <= '0;
            for (int j = 0; j < PHT_N; j++) pht_q[j] <= CNT_WEAK_NT;
        end else if (upd_valid) begin
            hist_q[wr_row]  <= {hist_q[wr_row][LH_W-2:0], upd_taken};
            pht_q[upd_hist] <= cnt_nxt;
        end
    end

    a_r5_local_newbit: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q[$past(wr_row)][0] == $past(upd_taken));

    a_r6_local_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && pht_q[upd_hist] == CNT_MAX)
        |=> pht_q[$past(upd_hist)] == CNT_MAX);

endmodule

// File: rtl/tp_global.sv
module tp_global #(
    parameter int GH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [GH_W-1:0] ghist,
    output logic            rd_taken,
    input  logic            upd_valid,
    input  logic            upd_taken,
    input  logic [GH_W-1:0] upd_ghist
);
    localparam int ENTRIES = 1 << GH_W;

    logic [GH_W-1:0] ghr_q;
    logic [1:0]      gpht_q [ENTRIES];
    logic [1:0]      cnt_cur, cnt_nxt;

    assign ghist    = ghr_q;
    assign rd_taken = gpht_q[ghr_q][1];

    always_comb begin
        cnt_cur = gpht_q[upd_ghist];
        cnt_nxt = cnt_cur;
        if (upd_taken && cnt_cur != 2'd3)
            cnt_nxt = cnt_cur + 2'd1;
        else if (!upd_taken && cnt_cur != 2'd0)
            cnt_nxt = cnt_cur - 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghr_q <= '0;
            for (int i = 0; i < ENTRIES; i++) gpht_q[i] <= 2'd1;
        end else if (upd_valid) begin
            ghr_q             <= {ghr_q[GH_W-2:0], upd_taken};
            gpht_q[upd_ghist] <= cnt_nxt;
        end
    end

    a_r5_ghr_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr_q[0] == $past(upd_taken)) &&
                      (ghr_q[GH_W-1:1] == $past(ghr_q[GH_W-2:0])));

    a_r9_ghr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr_q));

    a_r6_global_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && gpht_q[upd_ghist] == 2'd0)
        |=> gpht_q[$past(upd_ghist)] == 2'd0);

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser
    import tpred_pkg::*;
#(
    parameter int GH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GH_W-1:0] rd_idx,
    output logic            use_global,
    input  logic            upd_valid,
    input  logic [GH_W-1:0] wr_idx,
    input  logic            local_ok,
    input  logic            global_ok
);
    localparam int ENTRIES = 1 << GH_W;

    chooser_e ch_q [ENTRIES];
    chooser_e ch_nxt;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ch_q[i] <= CH_WEAK_LOCAL;
        end else if (upd_valid) begin
            ch_q[wr_idx] <= ch_nxt;
        end
    end

    // next state and output process
    always_comb begin
        ch_nxt     = chooser_next(ch_q[wr_idx], local_ok, global_ok);
        use_global = (ch_q[rd_idx] == CH_WEAK_GLOBAL) ||
                     (ch_q[rd_idx] == CH_STRONG_GLOBAL);
    end

    a_r7_chooser_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (local_ok == global_ok))
        |=> ch_q[$past(wr_idx)] == $past(ch_q[wr_idx]));

    a_r7_global_win_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && global_ok && !local_ok && ch_q[wr_idx] == CH_WEAK_LOCAL)
        |=> ch_q[$past(wr_idx)] == CH_WEAK_GLOBAL);

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int LROW_W = 10,
    parameter int LH_W   = 10,
    parameter int LCNT_W = 3,
    parameter int GH_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PC_W-1:0]        pred_pc,
    output logic                   pred_taken,
    output logic                   pred_use_global,
    output logic [GH_W+LH_W+1:0]   pred_snap,
    input  logic                   upd_valid,
    input  logic [PC_W-1:0]        upd_pc,
    input  logic                   upd_taken,
    input  logic [GH_W+LH_W+1:0]   upd_snap
);
    localparam int SNAP_W = GH_W + LH_W + 2;

    logic [LROW_W-1:0] rd_row, wr_row;
    logic [LH_W-1:0]   l_hist, s_lhist;
    logic [GH_W-1:0]   g_hist, s_ghist;
    logic              l_guess, g_guess, s_lguess, s_gguess;

    assign rd_row   = pred_pc[PC_LSB +: LROW_W];
    assign wr_row   = upd_pc[PC_LSB +: LROW_W];
    assign s_ghist  = upd_snap[SNAP_W-1 -: GH_W];
    assign s_lhist  = upd_snap[LH_W+1:2];
    assign s_lguess = upd_snap[1];
    assign s_gguess = upd_snap[0];

    tp_local #(.ROW_W(LROW_W), .LH_W(LH_W), .CNT_W(LCNT_W)) u_local (
        .clk(clk), .rst_n(rst_n),
        .rd_row(rd_row), .rd_hist(l_hist), .rd_taken(l_guess),
        .upd_valid(upd_valid), .wr_row(wr_row),
        .upd_taken(upd_taken), .upd_hist(s_lhist)
    );

    tp_global #(.GH_W(GH_W)) u_global (
        .clk(clk), .rst_n(rst_n),
        .ghist(g_hist), .rd_taken(g_guess),
        .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_ghist(s_ghist)
    );

    tp_chooser #(.GH_W(GH_W)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(g_hist), .use_global(pred_use_global),
        .upd_valid(upd_valid), .wr_idx(s_ghist),
        .local_ok(s_lguess == upd_taken), .global_ok(s_gguess == upd_taken)
    );

    assign pred_taken = pred_use_global ? g_guess : l_guess;
    assign pred_snap  = {g_hist, l_hist, l_guess, g_guess};

    a_r4_source_select: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == (pred_use_global ? pred_snap[0] : pred_snap[1]));

endmodule

// File: tb/tb_tourn_pred.sv
`timescale 1ns/1ps
module tb_tourn_pred;
    localparam int PC_W = 32, PC_LSB = 2, LROW_W = 3, LH_W = 4, LCNT_W = 3, GH_W = 5;
    localparam int SW = GH_W + LH_W + 2;
    localparam int NPC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
    logic pred_taken, pred_use_global, upd_valid = 1'b0, upd_taken = 1'b0;
    logic [SW-1:0] pred_snap, upd_snap = '0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tourn_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LROW_W(LROW_W), .LH_W(LH_W),
                 .LCNT_W(LCNT_W), .GH_W(GH_W)) dut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_use_global(pred_use_global), .pred_snap(pred_snap),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_snap(upd_snap));

    // behavioural model
    logic [LH_W-1:0] m_lh [1<<LROW_W];
    int              m_lp [1<<LH_W];
    logic [GH_W-1:0] m_gh;
    int              m_gp [1<<GH_W];
    int              m_ch [1<<GH_W];

    task automatic model_reset();
        for (int i = 0; i < (1<<LROW_W); i++) m_lh[i] = '0;
        for (int i = 0; i < (1<<LH_W); i++) m_lp[i] = 3;
        for (int i = 0; i < (1<<GH_W); i++) begin m_gp[i] = 1; m_ch[i] = 1; end
        m_gh = '0;
    endtask

    function automatic logic [SW-1:0] model_snap(logic [PC_W-1:0] pc);
        logic [LH_W-1:0] lh;
        lh = m_lh[pc[PC_LSB +: LROW_W]];
        return {m_gh, lh, logic'(m_lp[lh] >= 4), logic'(m_gp[m_gh] >= 2)};
    endfunction

    task automatic model_update(logic [PC_W-1:0] pc, logic t, logic [SW-1:0] s);
        int row, li, gi;
        logic lok, gok;
        row = int'(pc[PC_LSB +: LROW_W]);
        li = int'(s[LH_W+1:2]);
        gi = int'(s[SW-1 -: GH_W]);
        lok = (s[1] == t);
        gok = (s[0] == t);
        m_lh[row] = {m_lh[row][LH_W-2:0], t};
        m_gh = {m_gh[GH_W-2:0], t};
        if (t) begin
            if (m_lp[li] < 7) m_lp[li]++;
            if (m_gp[gi] < 3) m_gp[gi]++;
        end else begin
            if (m_lp[li] > 0) m_lp[li]--;
            if (m_gp[gi] > 0) m_gp[gi]--;
        end
        if (gok && !lok && m_ch[gi] < 3) m_ch[gi]++;
        else if (lok && !gok && m_ch[gi] > 0) m_ch[gi]--;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive prediction and optional update, check the
    // prediction against the pre-edge model, then apply the update.
    task automatic step(string tag, logic [PC_W-1:0] ppc, logic uv, logic [PC_W-1:0] upc,
                        logic ut, logic [SW-1:0] us, output logic [SW-1:0] exp_snap);
        logic ug;
        @(negedge clk);
        pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_snap = us;
        #1;
        exp_snap = model_snap(ppc);
        ug = (m_ch[m_gh] >= 2);
        chk({tag, " R2 local guess"}, 32'(pred_snap[1]), 32'(exp_snap[1]));
        chk({tag, " R3 global guess"}, 32'(pred_snap[0]), 32'(exp_snap[0]));
        chk({tag, " R5 histories"}, 32'(pred_snap[SW-1:2]), 32'(exp_snap[SW-1:2]));
        chk({tag, " R4 select"}, 32'(pred_use_global), 32'(ug));
        chk({tag, " R4 taken"}, 32'(pred_taken), 32'(ug ? exp_snap[0] : exp_snap[1]));
        @(posedge clk);
        if (uv) model_update(upc, ut, us);
    endtask

    function automatic logic [PC_W-1:0] pc_of(int k);
        return 32'h0000_1000 + 32'(k * 36);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] s, p_snap0, p_snap1;
        logic [PC_W-1:0] p_pc0, p_pc1;
        logic p_t0, p_t1, p_v0, p_v1, t;
        int cnt [NPC];
        void'($urandom(32'd2024));
        model_reset();
        for (int k = 0; k < NPC; k++) cnt[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state seen at the ports
        for (int k = 0; k < 4; k++) begin
            step("R1 reset", pc_of(k), 1'b0, '0, 1'b0, '0, s);
            chk("R1 snapshot zero", 32'(pred_snap), 32'd0);
            chk("R1 not taken", 32'(pred_taken), 32'd0);
        end

        // R6 saturation: one branch always taken, then always not taken
        for (int i = 0; i < 24; i++) begin
            step("R6 sat-up", pc_of(0), 1'b0, '0, 1'b0, '0, s);
            step("R6 sat-up", pc_of(0), 1'b1, pc_of(0), 1'b1, s, s);
        end
        chk("R6 strong taken", 32'(pred_taken), 32'd1);
        for (int i = 0; i < 24; i++) begin
            step("R6 sat-down", pc_of(0), 1'b0, '0, 1'b0, '0, s);
            step("R6 sat-down", pc_of(0), 1'b1, pc_of(0), 1'b0, s, s);
        end

        // R9: idle update inputs carrying junk must change nothing
        for (int i = 0; i < 40; i++)
            step("R9 idle", pc_of(i % NPC), 1'b0, $urandom, 1'($urandom), SW'($urandom), s);

        // R7 R8: random stream, each update lags its prediction by two cycles
        p_v0 = 0; p_v1 = 0; p_pc0 = '0; p_pc1 = '0; p_t0 = 0; p_t1 = 0;
        p_snap0 = '0; p_snap1 = '0;
        for (int i = 0; i < 2000; i++) begin
            int k;
            logic [PC_W-1:0] pc;
            k = int'($urandom_range(NPC - 1, 0));
            pc = pc_of(k);
            cnt[k]++;
            t = (cnt[k] % ((k % 4) + 2)) != 0;
            if ($urandom_range(9, 0) == 0) t = ~t;
            step("R7 R8 stream", pc, p_v1, p_pc1, p_t1, p_snap1, s);
            p_v1 = p_v0; p_pc1 = p_pc0; p_t1 = p_t0; p_snap1 = p_snap0;
            p_v0 = ($urandom_range(7, 0) != 0); p_pc0 = pc; p_t0 = t; p_snap0 = s;
        end

        // drain and re-check after R9 idle
        step("R8 drain", pc_of(1), p_v1, p_pc1, p_t1, p_snap1, s);
        step("R8 drain", pc_of(2), p_v0, p_pc0, p_t0, p_snap0, s);
        for (int i = 0; i < 16; i++)
            step("R9 idle-end", pc_of(i % NPC), 1'b0, $urandom, 1'($urandom), SW'($urandom), s);

        finished = 1;
        summary();
        $finish;
    end
endmodule